// File: doc/BRIEF.md
# Reloading Multi-Block DMA Channel

This block is one DMA channel. It copies a block of data items from a source address to a destination address over a single-beat memory bus. Each item is moved as one read followed by one write. Software programs the source address, the destination address, a control word and a configuration word through a small register port. It then sets the channel enable bit. The channel issues bus transactions only while both its own enable and a global enable are set.

The block keeps two copies of its working state. The programmed copy is what software wrote. The working copy holds the current addresses and the item count. Every time a block finishes, the working copy is restored from the programmed copy. This lets the same block repeat for as long as software keeps either reload bit set. At each block end the channel decides what happens next. With both reload bits clear, the block just finished was the last one: the channel flags the whole transfer as done and drops its enable. If the interrupt enable and the block mask are both set, it waits until software clears the block-done flag. Otherwise it starts the next block at once.

Either side may be marked as a peripheral. A peripheral side waits for a request before each of its transactions. That request comes either from a hardware request/acknowledge pin pair or from a software request register. A memory side never waits.

Top module: `dma_reload_chan`

## Requirements
- R1: At every block end the current source address, destination address and item count are restored from the programmed values, so the next block reads and writes the same addresses again.
- R2: Status bit 0 (block done, register 6) is set at every block end and cleared by writing 1 to it. Status bit 1 is transfer done. irq_o is high when the control interrupt enable (control bit 8) is 1 and a status bit is set whose mask bit (register 7, same position) is 1.
- R3: At a block end with both reload bits clear (configuration bit 0 for source, bit 1 for destination), transfer done is set, the enable bit (register 4 bit 0) reads 0 and no further bus transaction is issued.
- R4: When control bit 8 and mask bit 0 are both 1, the channel issues no bus transaction after a block end until block done is cleared, then continues. With either of the two at 0 it continues without waiting.
- R5: Address mode fields (source control bits 5:4, destination bits 7:6): 0 increments, 1 decrements, 2 or 3 holds the address fixed. The step is the byte size of that side's width.
- R6: Width fields (source bits 1:0, destination bits 3:2; 0 byte, 1 halfword, 2 or 3 word) are independent. The source item is masked to the source width, zero-extended, and written with bus_size_o set to the destination width.
- R7: A block moves N items, where N is control bits 27:16; a value of 0 moves one item.
- R8: Writing 1 to register 4 bit 0 enables the channel. No new transaction is issued unless register 5 bit 0 (global enable) is also 1. A transaction already on the bus completes.
- R9: A peripheral side (control bit 9 source, bit 10 destination) with hardware handshake (configuration bit 2 source, bit 3 destination, value 0) waits for its request pin before each transaction. After each completed transaction on that side, it pulses its acknowledge pin for one cycle.
- R10: A peripheral side with software handshake (select bit 1) waits for a software request instead: register 8 bit 0 for source, bit 1 for destination. Each request allows exactly one transaction. The request pin is ignored and no acknowledge is pulsed.
- R11: A memory side (peripheral bit 0) never waits for any request.
- R12: Writes to the source, destination and control registers (0, 1, 2) are ignored while the channel is enabled. The configuration register stays writable, so clearing the reload bits during a stall makes the next block the last.
- R13: After reset all registers read 0, irq_o is 0 and no bus request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| bus_req_o | output | 1 | Bus transaction request, held until acknowledged |
| bus_we_o | output | 1 | 1 write, 0 read |
| bus_addr_o | output | AW | Byte address |
| bus_size_o | output | 2 | 0 byte, 1 halfword, 2 word |
| bus_wdata_o | output | 32 | Write data, low-aligned |
| bus_rdata_i | input | 32 | Read data, valid with acknowledge |
| bus_ack_i | input | 1 | Transaction complete |
| src_req_i | input | 1 | Hardware request from source peripheral |
| src_ack_o | output | 1 | Acknowledge pulse to source peripheral |
| dst_req_i | input | 1 | Hardware request from destination peripheral |
| dst_ack_o | output | 1 | Acknowledge pulse to destination peripheral |
| irq_o | output | 1 | Interrupt |

## Verification
The main copy path is driven with several setups. Byte increments with a single block check count and ordering. Decrementing halfword reads into incrementing word writes show that widths and steps are separate and that data is zero-extended. A fixed destination shows the address holding still. Multi-block runs change source memory between blocks: new data at the old destination proves the addresses and count were reloaded. The same runs compare a stalled channel, which stays silent on the bus, with an unmasked one that keeps going. The handshake runs set hardware and software requests against memory sides. Counted reads, writes and acknowledge pulses show which side waited and for what.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int LEN_W = 12;

  localparam logic [1:0] AM_INC = 2'd0;
  localparam logic [1:0] AM_DEC = 2'd1;
  localparam logic [1:0] AM_FIX = 2'd2;

  localparam logic [3:0] RA_SRC  = 4'd0;
  localparam logic [3:0] RA_DST  = 4'd1;
  localparam logic [3:0] RA_CTRL = 4'd2;
  localparam logic [3:0] RA_CFG  = 4'd3;
  localparam logic [3:0] RA_EN   = 4'd4;
  localparam logic [3:0] RA_GLB  = 4'd5;
  localparam logic [3:0] RA_STAT = 4'd6;
  localparam logic [3:0] RA_MASK = 4'd7;
  localparam logic [3:0] RA_SWRQ = 4'd8;

  typedef struct packed {
    logic [3:0]       rsv_hi;
    logic [LEN_W-1:0] blk_len;
    logic [4:0]       rsv_mid;
    logic             dst_periph;
    logic             src_periph;
    logic             int_en;
    logic [1:0]       dst_mode;
    logic [1:0]       src_mode;
    logic [1:0]       dst_width;
    logic [1:0]       src_width;
  } ctrl_t;

  typedef struct packed {
    logic [27:0] rsv;
    logic        dst_hs_sw;
    logic        src_hs_sw;
    logic        rld_dst;
    logic        rld_src;
  } cfg_t;

  typedef enum logic [2:0] {
    S_IDLE, S_SRCW, S_RD, S_DSTW, S_WR, S_BEND, S_STALL
  } seq_state_e;

  function automatic logic [1:0] eff_width(logic [1:0] w);
    return (w == 2'd3) ? 2'd2 : w;
  endfunction

  function automatic logic [31:0] width_mask(logic [1:0] w);
    case (eff_width(w))
      2'd0:    return 32'h0000_00ff;
      2'd1:    return 32'h0000_ffff;
      default: return 32'hffff_ffff;
    endcase
  endfunction
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [3:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic [AW-1:0] prog_src_o,
  output logic [AW-1:0] prog_dst_o,
  output ctrl_t         ctrl_o,
  output cfg_t          cfg_o,
  output logic          ch_en_o,
  output logic          glb_en_o,
  output logic          start_o,
  output logic          blk_stat_o,
  output logic          blk_mask_o,
  output logic [1:0]    sw_pend_o,
  input  logic [1:0]    sw_take_i,
  input  logic          blk_set_i,
  input  logic          xfer_set_i,
  output logic          irq_o
);
  logic [AW-1:0] prog_src_q, prog_dst_q;
  ctrl_t         ctrl_q;
  cfg_t          cfg_q;
  logic          ch_en_q, glb_q;
  logic [1:0]    stat_q, mask_q, pend_q;

  logic wr_src, wr_dst, wr_ctrl;
  assign wr_src  = reg_we_i && reg_addr_i == RA_SRC  && !ch_en_q;
  assign wr_dst  = reg_we_i && reg_addr_i == RA_DST  && !ch_en_q;
  assign wr_ctrl = reg_we_i && reg_addr_i == RA_CTRL && !ch_en_q;
  assign start_o = reg_we_i && reg_addr_i == RA_EN && reg_wdata_i[0] && !ch_en_q;

  logic [1:0] stat_clr, pend_set;
  assign stat_clr = (reg_we_i && reg_addr_i == RA_STAT) ? reg_wdata_i[1:0] : 2'b00;
  assign pend_set = (reg_we_i && reg_addr_i == RA_SWRQ) ? reg_wdata_i[1:0] : 2'b00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_src_q <= '0;
      prog_dst_q <= '0;
      ctrl_q     <= '0;
      cfg_q      <= '0;
      ch_en_q    <= 1'b0;
      glb_q      <= 1'b0;
      stat_q     <= '0;
      mask_q     <= '0;
      pend_q     <= '0;
    end else begin
      if (wr_src)  prog_src_q <= reg_wdata_i[AW-1:0];
      if (wr_dst)  prog_dst_q <= reg_wdata_i[AW-1:0];
      if (wr_ctrl) ctrl_q     <= ctrl_t'(reg_wdata_i);
      if (reg_we_i && reg_addr_i == RA_CFG)  cfg_q  <= cfg_t'(reg_wdata_i);
      if (reg_we_i && reg_addr_i == RA_GLB)  glb_q  <= reg_wdata_i[0];
      if (reg_we_i && reg_addr_i == RA_MASK) mask_q <= reg_wdata_i[1:0];
      if (xfer_set_i)   ch_en_q <= 1'b0;
      else if (start_o) ch_en_q <= 1'b1;
      // a set in the same cycle as a clear wins
      stat_q <= (stat_q & ~stat_clr) | {xfer_set_i, blk_set_i};
      pend_q <= (pend_q & ~sw_take_i) | pend_set;
    end
  end

  always_comb begin
    case (reg_addr_i)
      RA_SRC:  reg_rdata_o = 32'(prog_src_q);
      RA_DST:  reg_rdata_o = 32'(prog_dst_q);
      RA_CTRL: reg_rdata_o = ctrl_q;
      RA_CFG:  reg_rdata_o = cfg_q;
      RA_EN:   reg_rdata_o = {31'd0, ch_en_q};
      RA_GLB:  reg_rdata_o = {31'd0, glb_q};
      RA_STAT: reg_rdata_o = {30'd0, stat_q};
      RA_MASK: reg_rdata_o = {30'd0, mask_q};
      RA_SWRQ: reg_rdata_o = {30'd0, pend_q};
      default: reg_rdata_o = '0;
    endcase
  end

  assign prog_src_o = prog_src_q;
  assign prog_dst_o = prog_dst_q;
  assign ctrl_o     = ctrl_q;
  assign cfg_o      = cfg_q;
  assign ch_en_o    = ch_en_q;
  assign glb_en_o   = glb_q;
  assign blk_stat_o = stat_q[0];
  assign blk_mask_o = mask_q[0];
  assign sw_pend_o  = pend_q;
  assign irq_o      = ctrl_q.int_en && |(stat_q & mask_q);

  a_r12_src_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_en_q && reg_we_i && reg_addr_i == RA_SRC) |=> $stable(prog_src_q));
  a_r2_blk_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_set_i |=> stat_q[0]);
endmodule

// File: rtl/dma_chan_agen.sv
module dma_chan_agen
  import dma_chan_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic          step_i,
  input  logic [1:0]    mode_i,
  input  logic [1:0]    width_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q, incr;
  assign incr = AW'(1) << eff_width(width_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= base_i;
    else if (step_i) begin
      case (mode_i)
        AM_INC:  addr_q <= addr_q + incr;
        AM_DEC:  addr_q <= addr_q - incr;
        default: addr_q <= addr_q;
      endcase
    end
  end
  assign addr_o = addr_q;

  a_r5_fixed_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && mode_i == AM_FIX) |=> $stable(addr_q));
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ctrl_t         ctrl_i,
  input  cfg_t          cfg_i,
  input  logic          ch_en_i,
  input  logic          glb_en_i,
  input  logic          start_i,
  input  logic          blk_stat_i,
  input  logic          blk_mask_i,
  input  logic [1:0]    sw_pend_i,
  output logic [1:0]    sw_take_o,
  output logic          blk_set_o,
  output logic          xfer_set_o,
  output logic          load_o,
  output logic [1:0]    step_o,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [1:0]    bus_size_o,
  output logic [31:0]   bus_wdata_o,
  input  logic [31:0]   bus_rdata_i,
  input  logic          bus_ack_i,
  input  logic          src_req_i,
  output logic          src_ack_o,
  input  logic          dst_req_i,
  output logic          dst_ack_o
);
  seq_state_e       state_q, state_d;
  logic [LEN_W-1:0] beat_q, len_eff;
  logic [31:0]      data_q;
  logic             src_ack_q, dst_ack_q;
  logic             run, src_rdy, dst_rdy, last, rd_done, wr_done, any_rld;

  assign run     = ch_en_i && glb_en_i;
  assign src_rdy = !ctrl_i.src_periph || (cfg_i.src_hs_sw ? sw_pend_i[0] : src_req_i);
  assign dst_rdy = !ctrl_i.dst_periph || (cfg_i.dst_hs_sw ? sw_pend_i[1] : dst_req_i);
  assign len_eff = (ctrl_i.blk_len == '0) ? LEN_W'(1) : ctrl_i.blk_len;
  assign last    = beat_q == len_eff - LEN_W'(1);
  assign rd_done = state_q == S_RD && bus_ack_i;
  assign wr_done = state_q == S_WR && bus_ack_i;
  assign any_rld = cfg_i.rld_src || cfg_i.rld_dst;

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:  if (ch_en_i) state_d = S_SRCW;
      S_SRCW:  if (run && src_rdy) state_d = S_RD;
      S_RD:    if (bus_ack_i) state_d = S_DSTW;
      S_DSTW:  if (run && dst_rdy) state_d = S_WR;
      S_WR:    if (bus_ack_i) state_d = last ? S_BEND : S_SRCW;
      S_BEND: begin
        if (!any_rld)                         state_d = S_IDLE;
        else if (ctrl_i.int_en && blk_mask_i) state_d = S_STALL;
        else                                  state_d = S_SRCW;
      end
      S_STALL: if (!blk_stat_i) state_d = S_SRCW;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      beat_q    <= '0;
      data_q    <= '0;
      src_ack_q <= 1'b0;
      dst_ack_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_i || state_q == S_BEND) beat_q <= '0;
      else if (wr_done && !last)        beat_q <= beat_q + LEN_W'(1);
      if (rd_done) data_q <= bus_rdata_i & width_mask(ctrl_i.src_width);
      src_ack_q <= rd_done && ctrl_i.src_periph && !cfg_i.src_hs_sw;
      dst_ack_q <= wr_done && ctrl_i.dst_periph && !cfg_i.dst_hs_sw;
    end
  end

  assign sw_take_o[0] = state_q == S_SRCW && run && ctrl_i.src_periph && cfg_i.src_hs_sw && sw_pend_i[0];
  assign sw_take_o[1] = state_q == S_DSTW && run && ctrl_i.dst_periph && cfg_i.dst_hs_sw && sw_pend_i[1];
  assign blk_set_o    = state_q == S_BEND;
  assign xfer_set_o   = state_q == S_BEND && !any_rld;
  assign load_o       = state_q == S_BEND;
  assign step_o       = {wr_done, rd_done};

  assign bus_req_o   = state_q == S_RD || state_q == S_WR;
  assign bus_we_o    = state_q == S_WR;
  assign bus_addr_o  = (state_q == S_WR) ? dst_addr_i : src_addr_i;
  assign bus_size_o  = eff_width((state_q == S_WR) ? ctrl_i.dst_width : ctrl_i.src_width);
  assign bus_wdata_o = data_q;
  assign src_ack_o   = src_ack_q;
  assign dst_ack_o   = dst_ack_q;

  a_r3_done_drops_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_set_o |=> !ch_en_i);
  a_r9_src_ack_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_ack_o |-> $past(bus_req_o && bus_ack_i && !bus_we_o));
  a_r8_no_issue_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == S_SRCW || state_q == S_DSTW) && !run) |=> !bus_req_o);
  a_r4_stall_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_STALL && blk_stat_i) |=> !bus_req_o);
  a_r7_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o)));
endmodule

// File: rtl/dma_reload_chan.sv
module dma_reload_chan
  import dma_chan_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [3:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [1:0]    bus_size_o,
  output logic [31:0]   bus_wdata_o,
  input  logic [31:0]   bus_rdata_i,
  input  logic          bus_ack_i,
  input  logic          src_req_i,
  output logic          src_ack_o,
  input  logic          dst_req_i,
  output logic          dst_ack_o,
  output logic          irq_o
);
  logic [AW-1:0] prog_src, prog_dst;
  ctrl_t         ctrl;
  cfg_t          cfg;
  logic          ch_en, glb_en, start, blk_stat, blk_mask, blk_set, xfer_set, seq_load;
  logic [1:0]    sw_pend, sw_take, step;

  logic [1:0][AW-1:0] side_base, side_addr;
  logic [1:0][1:0]    side_mode, side_width;

  dma_chan_regs #(.AW(AW)) i_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .prog_src_o(prog_src), .prog_dst_o(prog_dst), .ctrl_o(ctrl), .cfg_o(cfg),
    .ch_en_o(ch_en), .glb_en_o(glb_en), .start_o(start),
    .blk_stat_o(blk_stat), .blk_mask_o(blk_mask),
    .sw_pend_o(sw_pend), .sw_take_i(sw_take),
    .blk_set_i(blk_set), .xfer_set_i(xfer_set), .irq_o
  );

  assign side_base  = {prog_dst, prog_src};
  assign side_mode  = {ctrl.dst_mode, ctrl.src_mode};
  assign side_width = {ctrl.dst_width, ctrl.src_width};

  // index 0 source, index 1 destination
  for (genvar g = 0; g < 2; g++) begin : g_side
    dma_chan_agen #(.AW(AW)) i_agen (
      .clk_i, .rst_ni,
      .load_i (start || seq_load),
      .base_i (side_base[g]),
      .step_i (step[g]),
      .mode_i (side_mode[g]),
      .width_i(side_width[g]),
      .addr_o (side_addr[g])
    );
  end

  dma_chan_seq #(.AW(AW)) i_seq (
    .clk_i, .rst_ni,
    .ctrl_i(ctrl), .cfg_i(cfg), .ch_en_i(ch_en), .glb_en_i(glb_en),
    .start_i(start), .blk_stat_i(blk_stat), .blk_mask_i(blk_mask),
    .sw_pend_i(sw_pend), .sw_take_o(sw_take),
    .blk_set_o(blk_set), .xfer_set_o(xfer_set), .load_o(seq_load), .step_o(step),
    .src_addr_i(side_addr[0]), .dst_addr_i(side_addr[1]),
    .bus_req_o, .bus_we_o, .bus_addr_o, .bus_size_o, .bus_wdata_o,
    .bus_rdata_i, .bus_ack_i,
    .src_req_i, .src_ack_o, .dst_req_i, .dst_ack_o
  );
endmodule

// File: tb/test_dma_reload_chan.sv
`timescale 1ns/1ps
module test_dma_reload_chan;
  localparam int AW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic bus_req, bus_we, bus_ack = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [1:0] bus_size;
  logic [31:0] bus_wdata, bus_rdata = '0;
  logic src_req = 1'b0, dst_req = 1'b0, src_ack, dst_ack, irq;

  logic [7:0] mem [0:255];
  logic poke_en = 1'b0;
  logic [7:0] poke_a = '0, poke_d = '0;
  int nrd = 0, nwr = 0, nsack = 0, ndack = 0;
  int errors = 0, checks = 0;
  bit timeout = 0;

  always #5 clk = ~clk;

  dma_reload_chan #(.AW(AW)) i_dma_reload_chan (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr), .bus_size_o(bus_size),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata), .bus_ack_i(bus_ack),
    .src_req_i(src_req), .src_ack_o(src_ack), .dst_req_i(dst_req), .dst_ack_o(dst_ack),
    .irq_o(irq)
  );

  // one-wait-state byte memory, little endian
  always @(posedge clk) begin
    logic [7:0] a;
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= (i < 64) ? 8'(i) : 8'h00;
      bus_ack <= 1'b0;
    end else begin
      if (poke_en) mem[poke_a] <= poke_d;
      if (bus_req && !bus_ack) begin
        a = bus_addr[7:0];
        bus_ack <= 1'b1;
        if (bus_we) begin
          nwr <= nwr + 1;
          mem[a] <= bus_wdata[7:0];
          if (bus_size >= 2'd1) mem[8'(a+1)] <= bus_wdata[15:8];
          if (bus_size >= 2'd2) begin
            mem[8'(a+2)] <= bus_wdata[23:16];
            mem[8'(a+3)] <= bus_wdata[31:24];
          end
        end else begin
          nrd <= nrd + 1;
          bus_rdata <= {mem[8'(a+3)], mem[8'(a+2)], mem[8'(a+1)], mem[a]};
        end
      end else bus_ack <= 1'b0;
      if (src_ack) nsack <= nsack + 1;
      if (dst_ack) ndack <= ndack + 1;
    end
  end

  function automatic logic [31:0] mk_ctrl(int len, logic [1:0] sw, logic [1:0] dw,
      logic [1:0] sm, logic [1:0] dm, logic ie, logic sp, logic dp);
    return {4'b0, 12'(len), 5'b0, dp, sp, ie, dm, sm, dw, sw};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic poke(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    poke_en = 1'b1; poke_a = a; poke_d = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic wait_stat(int b);
    logic [31:0] v;
    for (int i = 0; i < 2000; i++) begin
      rd_reg(4'd6, v);
      if (v[b]) return;
    end
    chk("status wait", 32'd0, 32'd1);
  endtask

  task automatic setup(int s, int d, logic [31:0] c, logic [31:0] cf);
    wr_reg(4'd0, 32'(s));
    wr_reg(4'd1, 32'(d));
    wr_reg(4'd2, c);
    wr_reg(4'd3, cf);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 9; a++) begin
      rd_reg(4'(a), v);
      chk("R13 reg reset", v, 0);
    end
    chk("R13 irq reset", 32'(irq), 0);
    chk("R13 bus idle", 32'(bus_req), 0);
  endtask

  task automatic t_single_bytes;
    logic [31:0] v;
    wr_reg(4'd5, 1);
    setup('h10, 'h40, mk_ctrl(4, 0, 0, 0, 0, 0, 0, 0), 0);
    wr_reg(4'd4, 1);
    wait_stat(1);
    for (int i = 0; i < 4; i++) chk("R7 byte copy", 32'(mem[8'h40 + i]), 32'('h10 + i));
    chk("R7 count stops", 32'(mem[8'h44]), 0);
    rd_reg(4'd4, v); chk("R3 enable cleared", v, 0);
    rd_reg(4'd6, v); chk("R3 status both", v, 3);
    repeat (5) @(negedge clk);
    chk("R3 bus idle after", 32'(bus_req), 0);
    wr_reg(4'd6, 3);
  endtask

  task automatic t_widths;
    // source halfword decrement from 0x24, destination word increment at 0x60
    setup('h24, 'h60, mk_ctrl(3, 1, 2, 1, 0, 0, 0, 0), 0);
    wr_reg(4'd4, 1);
    wait_stat(1);
    for (int i = 0; i < 3; i++) begin
      int sa = 'h24 - 2 * i;
      chk("R6 low byte", 32'(mem[8'h60 + 4*i]), 32'(sa));
      chk("R5 dec step", 32'(mem[8'h61 + 4*i]), 32'(sa + 1));
      chk("R6 zero ext", 32'({mem[8'h63 + 4*i], mem[8'h62 + 4*i]}), 0);
    end
    wr_reg(4'd6, 3);
    // fixed destination byte
    setup('h30, 'h70, mk_ctrl(3, 0, 0, 0, 2, 0, 0, 0), 0);
    wr_reg(4'd4, 1);
    wait_stat(1);
    chk("R5 fixed dst", 32'(mem[8'h70]), 'h32);
    chk("R5 fixed no step", 32'(mem[8'h71]), 0);
    wr_reg(4'd6, 3);
  endtask

  task automatic t_stall_reload;
    logic [31:0] v;
    int b;
    wr_reg(4'd7, 1);
    setup('h08, 'h80, mk_ctrl(2, 0, 0, 0, 0, 1, 0, 0), 3);
    wr_reg(4'd4, 1);
    wait_stat(0);
    b = nrd + nwr;
    repeat (20) @(negedge clk);
    chk("R4 stall no bus", 32'(nrd + nwr), 32'(b));
    chk("R2 irq on block", 32'(irq), 1);
    rd_reg(4'd4, v); chk("R4 still enabled", v, 1);
    chk("R7 block1 b0", 32'(mem[8'h80]), 8);
    chk("R7 block1 b1", 32'(mem[8'h81]), 9);
    wr_reg(4'd0, 'h30);
    rd_reg(4'd0, v); chk("R12 src write ignored", v, 'h08);
    poke(8'h08, 8'hA5);
    poke(8'h09, 8'h5A);
    wr_reg(4'd3, 0);
    rd_reg(4'd3, v); chk("R12 cfg writable", v, 0);
    wr_reg(4'd6, 1);
    rd_reg(4'd6, v); chk("R2 w1c clears", v, 0);
    wait_stat(1);
    chk("R1 reload b0", 32'(mem[8'h80]), 'hA5);
    chk("R1 reload b1", 32'(mem[8'h81]), 'h5A);
    chk("R1 count reload", 32'(mem[8'h82]), 0);
    rd_reg(4'd4, v); chk("R3 enable cleared", v, 0);
    wr_reg(4'd6, 3);
    wr_reg(4'd7, 0);
  endtask

  task automatic t_autorun;
    logic [31:0] v;
    int b;
    setup('h00, 'h90, mk_ctrl(2, 0, 0, 0, 0, 0, 0, 0), 1);
    wr_reg(4'd4, 1);
    wait_stat(0);
    b = nwr;
    repeat (40) @(negedge clk);
    chk("R4 no stall unmasked", 32'(nwr >= b + 2), 1);
    chk("R2 irq masked", 32'(irq), 0);
    wr_reg(4'd5, 0);
    repeat (6) @(negedge clk);
    b = nrd + nwr;
    repeat (30) @(negedge clk);
    chk("R8 global off halts", 32'(nrd + nwr), 32'(b));
    wr_reg(4'd3, 0);
    wr_reg(4'd5, 1);
    wait_stat(1);
    chk("R1 auto b0", 32'(mem[8'h90]), 0);
    chk("R1 auto b1", 32'(mem[8'h91]), 1);
    chk("R1 auto end", 32'(mem[8'h92]), 0);
    rd_reg(4'd4, v); chk("R3 enable cleared", v, 0);
    wr_reg(4'd6, 3);
  endtask

  task automatic t_global_gate;
    int b;
    wr_reg(4'd5, 0);
    setup('h14, 'hA0, mk_ctrl(0, 0, 0, 0, 0, 0, 0, 0), 0);
    b = nrd + nwr;
    wr_reg(4'd4, 1);
    repeat (20) @(negedge clk);
    chk("R8 no start when off", 32'(nrd + nwr), 32'(b));
    wr_reg(4'd5, 1);
    wait_stat(1);
    chk("R7 len zero one item", 32'(mem[8'hA0]), 'h14);
    chk("R7 len zero stop", 32'(mem[8'hA1]), 0);
    wr_reg(4'd6, 3);
  endtask

  task automatic t_hw_handshake;
    int b, a;
    setup('h18, 'hB0, mk_ctrl(2, 0, 0, 2, 0, 0, 1, 0), 0);
    b = nrd; a = nsack;
    wr_reg(4'd4, 1);
    repeat (20) @(negedge clk);
    chk("R9 waits for request", 32'(nrd), 32'(b));
    src_req = 1'b1;
    wait_stat(1);
    src_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 ack pulses", 32'(nsack - a), 2);
    chk("R9 data b0", 32'(mem[8'hB0]), 'h18);
    chk("R9 data b1", 32'(mem[8'hB1]), 'h18);
    wr_reg(4'd6, 3);
  endtask

  task automatic t_sw_handshake;
    int r, w, a;
    dst_req = 1'b1;
    setup('h1C, 'hC0, mk_ctrl(2, 0, 0, 0, 0, 0, 0, 1), 32'h8);
    r = nrd; w = nwr; a = ndack;
    wr_reg(4'd4, 1);
    repeat (20) @(negedge clk);
    chk("R11 memory src no wait", 32'(nrd - r), 1);
    chk("R10 pin ignored", 32'(nwr - w), 0);
    wr_reg(4'd8, 2);
    repeat (20) @(negedge clk);
    chk("R10 one write per req", 32'(nwr - w), 1);
    chk("R11 second read", 32'(nrd - r), 2);
    wr_reg(4'd8, 2);
    wait_stat(1);
    chk("R10 data b0", 32'(mem[8'hC0]), 'h1C);
    chk("R10 data b1", 32'(mem[8'hC1]), 'h1D);
    chk("R10 no hw ack", 32'(ndack - a), 0);
    dst_req = 1'b0;
    wr_reg(4'd6, 3);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_single_bytes();
        t_widths();
        t_stall_reload();
        t_autorun();
        t_global_gate();
        t_hw_handshake();
        t_sw_handshake();
      end
      begin
        repeat (150000) @(posedge clk);
        timeout = 1;
      end
    join_any
    if (timeout) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=expired expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule